// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt requests from eight active-low external pins, from a set of active-high internal peripheral lines and from a 32-bit software flag word. It delivers one request to the processor together with the identity and level of the winning source. Every source carries a programmable three-bit level. Level 0 turns the source off. Each external pin is set to edge or level detection on its own.

Sources are numbered in a fixed order. External pins come first as 0..7. The internal lines follow as 8..(7+N_INT). The flag word is last, as source 8+N_INT (16 with the default parameters). A mask level blocks every request whose level is at or below it. Software reaches the registers through a plain write strobe with a combinational read port. The processor-side outputs are plain registered control pins with no handshake. The core reacts to them and clears its source.

Word addresses: 0 pending status (read one bit per source; a write of 1 to bit i clears the edge latch of pin i), 1 trigger select, 2 mask level, 3 flag word, 8+i level of source i.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset there is no request, the outputs are zero, and the mask, flag word, trigger and all level registers read as zero.
- R2: With trigger bit i at 0 (address 1), external pin i is pending while it is low and stops being pending once it is high again.
- R3: With trigger bit i at 1, a high-to-low transition on pin i, seen after a two-stage synchronizer, sets a latch that stays pending after the pin returns high. Writing 1 to bit i of address 0 clears it. Writing 0 leaves it set.
- R4: A source whose level is 0 never produces a request.
- R5: The request reports the pending source with the highest level. Among equal levels the lowest source number wins.
- R6: A source whose level is less than or equal to the mask (address 2, bits 2:0) is suppressed. Mask 7 suppresses everything.
- R7: The flag word (address 3) reads back as written. Any nonzero value makes source 8+N_INT pending.
- R8: Internal line k (active high, level sensitive) is source 8+k.
- R9: irq_req_o, irq_id_o and irq_lvl_o are registered. They change one clock after the pending state changes, and id and level are zero while there is no request.
- R10: A write to address 8+i stores bits 2:0 as the level of source i and reads back with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_irq_ni | input | 8 | External interrupt pins, active low |
| int_irq_i | input | N_INT | Internal peripheral requests, active high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_req_o | output | 1 | Request to the processor |
| irq_id_o | output | 5 | Number of the winning source |
| irq_lvl_o | output | 3 | Level of the winning source |

## Verification
The hardest state to reach is an edge latch that stays pending after its pin has gone back high. It must then survive a status write with a zero bit and disappear only on a write of one. The bench puts a pin in edge mode and drives a short low pulse through the synchronizer. It releases the pin, waits, and then checks the request and the status word around both kinds of clear write. Ties and mask boundaries are covered by table rows that pit sources of equal level against each other, and by rows that set the mask exactly equal to the best level.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 32;
  localparam int A_STATUS  = 0;
  localparam int A_TRIG    = 1;
  localparam int A_MASK    = 2;
  localparam int A_FLAG    = 3;
  localparam int A_PRIO    = 8;
endpackage

// File: rtl/irq_ext_detect.sv
module irq_ext_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic pend_o,
  output logic latch_o
);
  logic s1_q, s2_q, prev_q, latch_q;
  logic fall;

  assign fall = prev_q & ~s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      prev_q  <= 1'b1;
      latch_q <= 1'b0;
    end else begin
      s1_q   <= pin_ni;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      if (fall && edge_mode_i) latch_q <= 1'b1;
      else if (clr_i)          latch_q <= 1'b0;
    end
  end

  assign pend_o  = edge_mode_i ? latch_q : ~s2_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC   = 17,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        pend_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]      mask_i,
  output logic                   hit_o,
  output logic [ID_W-1:0]        id_o,
  output logic [PRIO_W-1:0]      lvl_o
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    hit_o = 1'b0;
    id_o  = '0;
    best  = mask_i;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > best)) begin
        hit_o = 1'b1;
        id_o  = ID_W'(i);
        best  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
    lvl_o = hit_o ? best : '0;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int N_EXT  = 8,
  parameter int N_INT  = 8,
  parameter int PRIO_W = 3,
  localparam int NSRC  = N_EXT + N_INT + 1,
  localparam int ID_W  = $clog2(NSRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EXT-1:0]  ext_irq_ni,
  input  logic [N_INT-1:0]  int_irq_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_req_o,
  output logic [ID_W-1:0]   irq_id_o,
  output logic [PRIO_W-1:0] irq_lvl_o
);
  localparam int FLAG_SRC = NSRC - 1;

  logic [N_EXT-1:0]        trig_q;
  logic [PRIO_W-1:0]       mask_q;
  logic [DATA_W-1:0]       flag_q;
  logic [NSRC*PRIO_W-1:0]  prio_q;
  logic [NSRC-1:0]         pend;
  logic [N_EXT-1:0]        edge_q;
  logic [N_EXT-1:0]        clr;
  logic                    hit;
  logic [ID_W-1:0]         hit_id;
  logic [PRIO_W-1:0]       hit_lvl;

  assign clr = (reg_wr_i && reg_addr_i == ADDR_W'(A_STATUS)) ? reg_wdata_i[N_EXT-1:0] : '0;

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    irq_ext_detect u_det (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pin_ni      (ext_irq_ni[g]),
      .edge_mode_i (trig_q[g]),
      .clr_i       (clr[g]),
      .pend_o      (pend[g]),
      .latch_o     (edge_q[g])
    );
  end

  assign pend[N_EXT +: N_INT] = int_irq_i;
  assign pend[FLAG_SRC]       = |flag_q;

  irq_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .pend_i (pend),
    .prio_i (prio_q),
    .mask_i (mask_q),
    .hit_o  (hit),
    .id_o   (hit_id),
    .lvl_o  (hit_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= '0;
      mask_q <= '0;
      flag_q <= '0;
      prio_q <= '0;
    end else if (reg_wr_i) begin
      if (reg_addr_i == ADDR_W'(A_TRIG)) trig_q <= reg_wdata_i[N_EXT-1:0];
      if (reg_addr_i == ADDR_W'(A_MASK)) mask_q <= reg_wdata_i[PRIO_W-1:0];
      if (reg_addr_i == ADDR_W'(A_FLAG)) flag_q <= reg_wdata_i;
      for (int i = 0; i < NSRC; i++) begin
        if (reg_addr_i == ADDR_W'(A_PRIO + i))
          prio_q[i*PRIO_W +: PRIO_W] <= reg_wdata_i[PRIO_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_req_o <= 1'b0;
      irq_id_o  <= '0;
      irq_lvl_o <= '0;
    end else begin
      irq_req_o <= hit;
      irq_id_o  <= hit_id;
      irq_lvl_o <= hit_lvl;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(A_STATUS))    reg_rdata_o[NSRC-1:0]   = pend;
    else if (reg_addr_i == ADDR_W'(A_TRIG)) reg_rdata_o[N_EXT-1:0]  = trig_q;
    else if (reg_addr_i == ADDR_W'(A_MASK)) reg_rdata_o[PRIO_W-1:0] = mask_q;
    else if (reg_addr_i == ADDR_W'(A_FLAG)) reg_rdata_o             = flag_q;
    else begin
      for (int i = 0; i < NSRC; i++) begin
        if (reg_addr_i == ADDR_W'(A_PRIO + i))
          reg_rdata_o[PRIO_W-1:0] = prio_q[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N_EXT  = 8,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_req_o,
  input logic [ID_W-1:0]   irq_id_o,
  input logic [PRIO_W-1:0] irq_lvl_o,
  input logic [PRIO_W-1:0] mask_q,
  input logic [31:0]       flag_q,
  input logic [PRIO_W-1:0] flag_prio,
  input logic [N_EXT-1:0]  edge_q,
  input logic              reg_wr_i,
  input logic [4:0]        reg_addr_i
);
  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_req_o |-> (irq_id_o == '0 && irq_lvl_o == '0));

  a_r4_level_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_lvl_o != '0));

  a_r6_above_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_lvl_o > $past(mask_q)));

  a_r7_flag_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q != '0) && (flag_prio > mask_q)) |=> irq_req_o);

  a_r3_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == 5'd0) |=> ((edge_q & $past(edge_q)) == $past(edge_q)));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_EXT(N_EXT), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_req_o  (irq_req_o),
  .irq_id_o   (irq_id_o),
  .irq_lvl_o  (irq_lvl_o),
  .mask_q     (mask_q),
  .flag_q     (flag_q),
  .flag_prio  (prio_q[(NSRC-1)*PRIO_W +: PRIO_W]),
  .edge_q     (edge_q),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ext_n = 8'hff;
  logic [7:0]  int_src = 8'h00;
  logic        wr = 1'b0;
  logic [4:0]  addr = 5'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        req;
  logic [4:0]  id;
  logic [2:0]  lvl;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  irq_prio_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_irq_ni(ext_n), .int_irq_i(int_src),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_req_o(req), .irq_id_o(id), .irq_lvl_o(lvl)
  );

  // {ext_n, int_src, mask, exp_req, exp_id, exp_lvl}
  localparam logic [27:0] VEC [9] = '{
    {8'hff, 8'h00, 3'd0, 1'b0, 5'd0,  3'd0},  // R2 idle
    {8'hfe, 8'h00, 3'd0, 1'b1, 5'd0,  3'd3},  // R2 pin0 low
    {8'hf9, 8'h00, 3'd0, 1'b1, 5'd1,  3'd5},  // R5 tie 1 vs 2
    {8'hf7, 8'h00, 3'd0, 1'b0, 5'd0,  3'd0},  // R4 level 0
    {8'hfd, 8'h02, 3'd0, 1'b1, 5'd9,  3'd7},  // R8 internal wins
    {8'hfd, 8'h00, 3'd5, 1'b0, 5'd0,  3'd0},  // R6 equal to mask
    {8'h7d, 8'h00, 3'd5, 1'b1, 5'd7,  3'd6},  // R6 above mask
    {8'hbf, 8'hfc, 3'd1, 1'b1, 5'd6,  3'd2},  // R5 many ties
    {8'hfe, 8'h01, 3'd7, 1'b0, 5'd0,  3'd0}   // R6 mask 7
  };
  localparam logic [2:0] PRIOS [17] = '{3'd3, 3'd5, 3'd5, 3'd0, 3'd1, 3'd1, 3'd2, 3'd6,
                                        3'd4, 3'd7, 3'd2, 3'd2, 3'd2, 3'd2, 3'd2, 3'd2, 3'd6};

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1 reset state
    check("R1 req", {31'd0, req}, 32'd0);
    check("R1 id/lvl", {24'd0, id, lvl}, 32'd0);
    rreg(5'd2, r);  check("R1 mask", r, 32'd0);
    rreg(5'd3, r);  check("R1 flag", r, 32'd0);
    rreg(5'd9, r);  check("R1 prio", r, 32'd0);
    rreg(5'd1, r);  check("R1 trig", r, 32'd0);

    // R10 readback truncation
    wreg(5'd8, 32'hffff_fffd);
    rreg(5'd8, r);  check("R10 prio readback", r, 32'd5);

    for (int i = 0; i < 17; i++) wreg(5'(8 + i), {29'd0, PRIOS[i]});

    // table of level-mode vectors
    for (int v = 0; v < 9; v++) begin
      ext_n = VEC[v][27:20];
      int_src = VEC[v][19:12];
      wreg(5'd2, {29'd0, VEC[v][11:9]});
      wait_cyc(4);
      check("R5/R6 vector req", {31'd0, req}, {31'd0, VEC[v][8]});
      check("R5/R6 vector id/lvl", {24'd0, id, lvl}, {24'd0, VEC[v][7:0]});
    end
    ext_n = 8'hff; int_src = 8'h00;
    wreg(5'd2, 32'd0);
    wait_cyc(4);
    check("R2 release", {31'd0, req}, 32'd0);

    // R3 edge latch
    wreg(5'd1, 32'h1);
    ext_n[0] = 1'b0;
    wait_cyc(3);
    ext_n[0] = 1'b1;
    wait_cyc(5);
    check("R3 latched req", {24'd0, req, id, lvl}, {24'd0, 1'b1, 5'd0, 3'd3});
    rreg(5'd0, r);  check("R3 status bit", r, 32'h1);
    wreg(5'd0, 32'h0);
    wait_cyc(2);
    check("R3 zero write keeps", {31'd0, req}, 32'd1);
    wreg(5'd0, 32'h1);
    wait_cyc(1);
    check("R3 clear", {31'd0, req}, 32'd0);
    rreg(5'd0, r);  check("R3 status cleared", r, 32'd0);

    // R7 flag and R9 timing
    wreg(5'd3, 32'h8000_0000);
    check("R9 one-cycle delay", {31'd0, req}, 32'd0);
    @(negedge clk);
    check("R7 flag req", {24'd0, req, id, lvl}, {24'd0, 1'b1, 5'd16, 3'd6});
    rreg(5'd3, r);  check("R7 flag readback", r, 32'h8000_0000);
    wreg(5'd3, 32'd0);
    wait_cyc(1);
    check("R7 flag cleared", {31'd0, req}, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule